// File: doc/BRIEF.md
# Read Response Capture Buffer

After a bus turnaround, the receive path hands this block the packet that the peripheral sent back. The stream is one byte per cycle, qualified by a valid strobe, and the first and last bytes carry start and end markers. The block keeps the packet exactly as it arrived in a fixed 16-byte window, which software reads as four 32-bit words. It also works out from the stored header how many payload bytes software may use and at which byte of the window they begin.

A complete packet raises a read-ready flag. The block then holds the link: its busy flag stays set and it ignores any further traffic until software writes the read-acknowledge strobe. A second set of bytes therefore cannot overwrite a response that software has not read yet. Bytes that go past the window are dropped, and a truncation flag records the loss.

Top module: `rdresp_capture`

## Requirements
- R1: After reset, `status`, `data_cnt`, `data_ofs` and all four buffer words read as zero.
- R2: A byte with `rx_valid` and `rx_sop` set starts a capture. The whole window is cleared, that byte is stored at index 0, and each later valid byte goes to the next index. Word k returns bytes 4k..4k+3 with byte 4k in bits 7:0 (little-endian).
- R3: Type byte 0x11 or 0x21 gives `data_cnt`=1. Type 0x12 or 0x22 gives `data_cnt`=2. Both have `data_ofs`=1.
- R4: Type byte 0x1A or 0x1C gives `data_cnt` equal to byte1 + 256*byte2, capped at 10, and `data_ofs`=4 whenever that count is nonzero.
- R5: Type byte 0x02, and every type not named in R3 or R4, gives `data_cnt`=0. Whenever `data_cnt` is 0, `data_ofs` is 0.
- R6: `status` bit 0 (read-ready) rises in the cycle after the byte carrying `rx_eop` is accepted. While it is low, `data_cnt` and `data_ofs` are 0.
- R7: `status` bit 31 (busy) is set from the accepted start byte until an `ack_wr` pulse arrives while read-ready is set. A pulse at any other time has no effect.
- R8: While read-ready is set, incoming bytes, including start bytes, leave the buffer, the count and the flags unchanged.
- R9: Bytes beyond index 15 are dropped, and `status` bit 1 (truncated) is set until the next capture starts.
- R10: A start byte that arrives in the middle of a capture restarts the capture with a cleared window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte strobe from the receive path |
| rx_sop | input | 1 | Marks the first byte of a packet |
| rx_eop | input | 1 | Marks the last byte of a packet |
| rx_byte | input | 8 | Received byte |
| ack_wr | input | 1 | Software read-acknowledge strobe |
| word_sel | input | 2 | Selects which buffer word to read |
| word_data | output | 32 | Selected buffer word |
| status | output | 32 | Bit 0 read-ready, bit 1 truncated, bit 31 busy |
| data_cnt | output | 4 | Number of valid payload bytes |
| data_ofs | output | 3 | Byte index where the payload starts |

## Verification
The hardest state to reach from the ports is a held response that must survive more traffic. That means a start byte, or a full packet, arriving while read-ready is set, and acknowledge pulses arriving in the middle of a capture or while idle. Directed sequences build exactly these situations and then compare every word and flag against the held packet. Random packets of 1 to 20 bytes draw their type bytes from the known codes and from arbitrary values. Long-response length fields are biased toward both sides of the cap of 10, so truncation, capping and the zero-count types all appear many times.

// File: rtl/rdcap_pkg.sv
package rdcap_pkg;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_FILL = 2'd1,
    HS_HOLD = 2'd2
  } hs_state_e;

  typedef enum logic [1:0] {
    RC_NONE   = 2'd0,
    RC_SHORT1 = 2'd1,
    RC_SHORT2 = 2'd2,
    RC_LONG   = 2'd3
  } resp_class_e;

  localparam logic [7:0] DT_ACK_ERR    = 8'h02;
  localparam logic [7:0] DT_GEN_SHORT1 = 8'h11;
  localparam logic [7:0] DT_GEN_SHORT2 = 8'h12;
  localparam logic [7:0] DT_DCS_SHORT1 = 8'h21;
  localparam logic [7:0] DT_DCS_SHORT2 = 8'h22;
  localparam logic [7:0] DT_GEN_LONG   = 8'h1A;
  localparam logic [7:0] DT_DCS_LONG   = 8'h1C;

  function automatic resp_class_e classify(input logic [7:0] dt);
    resp_class_e rc;
    case (dt)
      DT_GEN_SHORT1, DT_DCS_SHORT1: rc = RC_SHORT1;
      DT_GEN_SHORT2, DT_DCS_SHORT2: rc = RC_SHORT2;
      DT_GEN_LONG,   DT_DCS_LONG:   rc = RC_LONG;
      default:                      rc = RC_NONE;
    endcase
    return rc;
  endfunction

endpackage

// File: rtl/rdcap_handshake.sv
module rdcap_handshake
  import rdcap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_valid,
  input  logic rx_sop,
  input  logic rx_eop,
  input  logic ack_wr,
  output logic clr_load,
  output logic app_en,
  output logic ready,
  output logic busy
);

  hs_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      HS_IDLE: begin
        if (rx_valid && rx_sop) st_d = rx_eop ? HS_HOLD : HS_FILL;
      end
      HS_FILL: begin
        if (rx_valid && rx_eop) st_d = HS_HOLD;
      end
      HS_HOLD: begin
        if (ack_wr) st_d = HS_IDLE;
      end
      default: st_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= HS_IDLE;
    else        st_q <= st_d;
  end

  assign clr_load = rx_valid && rx_sop && (st_q != HS_HOLD);
  assign app_en   = rx_valid && !rx_sop && (st_q == HS_FILL);
  assign ready    = (st_q == HS_HOLD);
  assign busy     = (st_q != HS_IDLE);

endmodule

// File: rtl/rdcap_store.sv
module rdcap_store #(
  parameter int BUF_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_load,
  input  logic                   app_en,
  input  logic [7:0]             in_byte,
  output logic [BUF_BYTES*8-1:0] buf_flat,
  output logic                   trunc
);

  localparam int PTR_W = $clog2(BUF_BYTES + 1);
  localparam logic [PTR_W-1:0] PTR_FULL = PTR_W'(BUF_BYTES);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             trunc_q, trunc_d;

  always_comb begin
    ptr_d   = ptr_q;
    trunc_d = trunc_q;
    if (clr_load) begin
      ptr_d   = PTR_W'(1);
      trunc_d = 1'b0;
    end else if (app_en) begin
      if (ptr_q == PTR_FULL) trunc_d = 1'b1;
      else                   ptr_d   = ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      trunc_q <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      trunc_q <= trunc_d;
    end
  end

  for (genvar i = 0; i < BUF_BYTES; i++) begin : g_byte
    logic [7:0] mem_q, mem_d;
    logic       mem_en;

    always_comb begin
      mem_en = 1'b0;
      mem_d  = mem_q;
      if (clr_load) begin
        mem_en = 1'b1;
        mem_d  = (i == 0) ? in_byte : 8'h00;
      end else if (app_en && (ptr_q == PTR_W'(i))) begin
        mem_en = 1'b1;
        mem_d  = in_byte;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q <= 8'h00;
      else if (mem_en) mem_q <= mem_d;
    end

    assign buf_flat[i*8 +: 8] = mem_q;
  end

  assign trunc = trunc_q;

endmodule

// File: rtl/rdcap_decode.sv
module rdcap_decode
  import rdcap_pkg::*;
#(
  parameter int MAX_PAYLOAD = 10,
  parameter int CNT_W       = 4,
  parameter int OFS_W       = 3,
  parameter int SHORT_OFS   = 1,
  parameter int LONG_OFS    = 4
) (
  input  logic             valid,
  input  logic [7:0]       dtype,
  input  logic [7:0]       len_lo,
  input  logic [7:0]       len_hi,
  output logic [CNT_W-1:0] cnt,
  output logic [OFS_W-1:0] ofs
);

  localparam logic [15:0] CAP = 16'(MAX_PAYLOAD);

  resp_class_e rc;
  logic [15:0] long_len;
  logic [CNT_W-1:0] long_cnt;

  assign rc       = classify(dtype);
  assign long_len = {len_hi, len_lo};
  assign long_cnt = (long_len > CAP) ? CNT_W'(MAX_PAYLOAD) : CNT_W'(long_len);

  always_comb begin
    cnt = '0;
    ofs = '0;
    if (valid) begin
      case (rc)
        RC_SHORT1: begin cnt = CNT_W'(1); ofs = OFS_W'(SHORT_OFS); end
        RC_SHORT2: begin cnt = CNT_W'(2); ofs = OFS_W'(SHORT_OFS); end
        RC_LONG: begin
          cnt = long_cnt;
          ofs = (long_cnt != '0) ? OFS_W'(LONG_OFS) : '0;
        end
        default: begin cnt = '0; ofs = '0; end
      endcase
    end
  end

endmodule

// File: rtl/rdresp_capture.sv
module rdresp_capture #(
  parameter int BUF_BYTES   = 16,
  parameter int WORD_W      = 32,
  parameter int MAX_PAYLOAD = 10,
  parameter int CNT_W       = 4,
  parameter int OFS_W       = 3,
  parameter int SEL_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sop,
  input  logic              rx_eop,
  input  logic [7:0]        rx_byte,
  input  logic              ack_wr,
  input  logic [SEL_W-1:0]  word_sel,
  output logic [WORD_W-1:0] word_data,
  output logic [31:0]       status,
  output logic [CNT_W-1:0]  data_cnt,
  output logic [OFS_W-1:0]  data_ofs
);

  localparam int WORD_BYTES = WORD_W / 8;
  localparam int N_WORDS    = BUF_BYTES / WORD_BYTES;

  logic                   clr_load, app_en, ready, busy, trunc;
  logic [BUF_BYTES*8-1:0] buf_flat;
  logic [WORD_W-1:0]      words [N_WORDS];

  rdcap_handshake u_hs (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_sop   (rx_sop),
    .rx_eop   (rx_eop),
    .ack_wr   (ack_wr),
    .clr_load (clr_load),
    .app_en   (app_en),
    .ready    (ready),
    .busy     (busy)
  );

  rdcap_store #(.BUF_BYTES(BUF_BYTES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_load (clr_load),
    .app_en   (app_en),
    .in_byte  (rx_byte),
    .buf_flat (buf_flat),
    .trunc    (trunc)
  );

  rdcap_decode #(
    .MAX_PAYLOAD (MAX_PAYLOAD),
    .CNT_W       (CNT_W),
    .OFS_W       (OFS_W)
  ) u_dec (
    .valid  (ready),
    .dtype  (buf_flat[7:0]),
    .len_lo (buf_flat[15:8]),
    .len_hi (buf_flat[23:16]),
    .cnt    (data_cnt),
    .ofs    (data_ofs)
  );

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    assign words[w] = buf_flat[w*WORD_W +: WORD_W];
  end

  always_comb begin
    word_data = '0;
    for (int k = 0; k < N_WORDS; k++) begin
      if (word_sel == SEL_W'(k)) word_data = words[k];
    end
  end

  assign status = {busy, 29'd0, trunc, ready};

endmodule

// File: rtl/rdcap_checker.sv
module rdcap_checker #(
  parameter int MAX_PAYLOAD = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic        rx_sop,
  input logic        ack_wr,
  input logic [31:0] status,
  input logic [3:0]  data_cnt,
  input logic [2:0]  data_ofs,
  input logic [31:0] word_data
);

  AST_CNT_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    data_cnt <= 4'(MAX_PAYLOAD)); // R4

  AST_ZERO_CNT_NO_OFS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_cnt == 4'd0) |-> (data_ofs == 3'd0)); // R5

  AST_IDLE_NO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    !status[0] |-> (data_cnt == 4'd0)); // R6

  AST_READY_IS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> status[31]); // R7

  AST_BUSY_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (status[31] && !(status[0] && ack_wr)) |=> status[31]); // R7

  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && ack_wr) |=> !status[31]); // R7

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !ack_wr) |=> ($stable(data_cnt) && $stable(data_ofs) && $stable(status[1]))); // R8

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_sop && !status[0]) |=> status[31]); // R2

endmodule

bind rdresp_capture rdcap_checker #(.MAX_PAYLOAD(MAX_PAYLOAD)) u_rdcap_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_valid  (rx_valid),
  .rx_sop    (rx_sop),
  .ack_wr    (ack_wr),
  .status    (status),
  .data_cnt  (data_cnt),
  .data_ofs  (data_ofs),
  .word_data (word_data)
);

// File: tb/rdresp_capture_bench.sv
module rdresp_capture_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0, ack_wr = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic [1:0]  word_sel = 2'd0;
  logic [31:0] word_data, status;
  logic [3:0]  data_cnt;
  logic [2:0]  data_ofs;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model: 0 idle, 1 filling, 2 holding
  int         m_st = 0;
  logic [7:0] m_buf [16];
  int         m_ptr = 0;
  bit         m_trunc = 1'b0;
  logic [7:0] pk [24];

  always #2 clk = ~clk;

  rdresp_capture u_rdresp_capture (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sop(rx_sop),
    .rx_eop(rx_eop), .rx_byte(rx_byte), .ack_wr(ack_wr),
    .word_sel(word_sel), .word_data(word_data), .status(status),
    .data_cnt(data_cnt), .data_ofs(data_ofs)
  );

  function automatic int exp_cnt();
    int l;
    if (m_st != 2) return 0;
    case (m_buf[0])
      8'h11, 8'h21: return 1;
      8'h12, 8'h22: return 2;
      8'h1A, 8'h1C: begin
        l = int'(m_buf[1]) + 256 * int'(m_buf[2]);
        return (l > 10) ? 10 : l;
      end
      default: return 0;
    endcase
  endfunction

  function automatic int exp_ofs();
    if (exp_cnt() == 0) return 0;
    if (m_buf[0] == 8'h1A || m_buf[0] == 8'h1C) return 4;
    return 1;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [31:0] es;
    es = {(m_st != 0), 29'd0, m_trunc, (m_st == 2)};
    chk(tag, "status", status, es);
    chk(tag, "data_cnt", data_cnt, exp_cnt());
    chk(tag, "data_ofs", data_ofs, exp_ofs());
    for (int k = 0; k < 4; k++) begin
      word_sel = 2'(k);
      #0.5;
      chk(tag, $sformatf("word%0d", k), word_data,
          {m_buf[4*k+3], m_buf[4*k+2], m_buf[4*k+1], m_buf[4*k]});
    end
  endtask

  task automatic drive(bit sop, bit eop, logic [7:0] b);
    rx_valid = 1'b1; rx_sop = sop; rx_eop = eop; rx_byte = b;
    if (sop && m_st != 2) begin
      foreach (m_buf[i]) m_buf[i] = 8'h00;
      m_buf[0] = b; m_ptr = 1; m_trunc = 1'b0;
      m_st = eop ? 2 : 1;
    end else if (!sop && m_st == 1) begin
      if (m_ptr < 16) begin m_buf[m_ptr] = b; m_ptr++; end
      else m_trunc = 1'b1;
      if (eop) m_st = 2;
    end
    @(posedge clk); #1;
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
  endtask

  task automatic send(int len, bit with_eop);
    for (int i = 0; i < len; i++) drive(i == 0, with_eop && (i == len - 1), pk[i]);
  endtask

  task automatic ack();
    ack_wr = 1'b1;
    if (m_st == 2) m_st = 0;
    @(posedge clk); #1;
    ack_wr = 1'b0;
  endtask

  task automatic fill(logic [7:0] t, int seed_base);
    pk[0] = t;
    for (int i = 1; i < 24; i++) pk[i] = 8'(seed_base + 7 * i);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] codes [8];
    void'($urandom(32'h5EED_0042));
    codes = '{8'h11, 8'h12, 8'h21, 8'h22, 8'h1A, 8'h1C, 8'h02, 8'h00};
    foreach (m_buf[i]) m_buf[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check_all("R1");

    // R3 short one-byte response
    fill(8'h11, 3); send(4, 1); check_all("R3"); ack(); check_all("R7");
    // R3 two-byte DCS response
    fill(8'h22, 9); send(3, 1); check_all("R3"); ack();
    // R4 long response with count 6
    fill(8'h1A, 1); pk[1] = 8'd6; pk[2] = 8'd0; send(10, 1); check_all("R4"); ack();
    // R4 long response count 300 capped
    fill(8'h1C, 5); pk[1] = 8'd44; pk[2] = 8'd1; send(14, 1); check_all("R4"); ack();
    // R4 long with zero length
    fill(8'h1A, 2); pk[1] = 8'd0; pk[2] = 8'd0; send(4, 1); check_all("R4"); ack();
    // R5 acknowledge-and-error report, unknown type
    fill(8'h02, 4); send(4, 1); check_all("R5"); ack();
    fill(8'h55, 6); send(6, 1); check_all("R5"); ack();
    // R9 overflow, R2 layout
    fill(8'h1C, 8); pk[1] = 8'd9; pk[2] = 8'd0; send(20, 1); check_all("R9"); ack();
    check_all("R9");
    // R6 mid-capture: not ready, count zero; R7 ack during fill ignored
    fill(8'h12, 10); send(3, 0); check_all("R6"); ack(); check_all("R7");
    // R10 restart mid-capture
    fill(8'h21, 12); send(5, 1); check_all("R10");
    // R8 held: new packet ignored, ack in idle later ignored
    fill(8'h1A, 20); pk[1] = 8'd3; send(8, 1); check_all("R8");
    drive(1'b1, 1'b1, 8'h11); check_all("R8");
    ack(); check_all("R7"); ack(); check_all("R7");
    // R2 single-byte packet with sop and eop together
    drive(1'b1, 1'b1, 8'h12); check_all("R2"); ack();

    // random packets
    for (int n = 0; n < 60; n++) begin
      int len;
      len = 1 + int'($urandom % 20);
      fill(codes[$urandom % 8], int'($urandom % 256));
      if (pk[0] == 8'h00) pk[0] = 8'($urandom);
      pk[1] = 8'($urandom % 14);
      pk[2] = ($urandom % 4 == 0) ? 8'd1 : 8'd0;
      send(len, 1);
      if ($urandom % 2 == 0) begin @(posedge clk); #1; end
      check_all("R2");
      ack();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule